// File: doc/BRIEF.md
# Clock Configuration Register with Clamped System Divider

This block holds a 32-bit clock configuration word written and read over a simple register bus, and turns it into a system clock enable. The word carries a 4-bit divide code, a bit that requests the divider, and two PLL control bits: power-down and an active-low output enable. A source-select input picks between the PLL (200 MHz) and a non-PLL source. The divide ratio is the code plus one.

With the PLL selected, the divider is always in use and its ratio is held to at least /8, so the system clock never goes above 25 MHz. The divide field reads back at that floor too. The code written by software is stored unchanged. The clamp is applied only on the way out, so if the source later moves to the non-PLL input, the low code written earlier takes effect. With the non-PLL source, low codes are used as written. Code zero is treated as /2. If the divider is not requested, the enable is high every cycle.

The outputs are a one-cycle system clock enable pulse, a PLL-running flag, and the effective divide ratio.

Top module: `clk_cfg_divider`

## Requirements
- R1: After reset the configuration word reads 0x07803000: divide code 0xF in bits 26:23, divider request bit 22 = 0, PLL power-down bit 13 = 1, PLL output-enable bit 12 = 1. All other bits read 0.
- R2: A write stores bits 26:23, 22, 13 and 12. With srcBypass=1, those bits read back exactly as written.
- R3: With srcBypass=0 (PLL source), the divider is in use whatever bit 22 holds. effDivisor equals max(code,7)+1, so it is between 8 and 16.
- R4: With srcBypass=0, a stored code below 7 reads back as 7 in bits 26:23.
- R5: The stored code is not changed by the clamp. Switching srcBypass to 1 makes a low code written earlier read back and take effect as written.
- R6: With srcBypass=1, bit 22 = 0 makes effDivisor 1 and sysClkEn high on every cycle. Bit 22 = 1 makes effDivisor equal code+1.
- R7: With srcBypass=1 and bit 22 = 1, code 0 gives effDivisor 2.
- R8: pllRunning is 1 exactly when bits 13 and 12 of the stored word are both 0.
- R9: While the divider is in use, sysClkEn pulses for one cycle in every effDivisor cycles. The counter restarts when the ratio changes.
- R10: Writes to bits 21:14 and to all other unlisted bits change neither the readback nor any output. Those bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each cycle is one source clock cycle |
| rstN | input | 1 | Active-low synchronous reset |
| srcBypass | input | 1 | 1 selects the non-PLL source, 0 selects the PLL |
| cfgWe | input | 1 | Register write strobe |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Register readback, with the divide field clamped |
| sysClkEn | output | 1 | System clock enable pulse |
| pllRunning | output | 1 | PLL powered and its output enabled |
| effDivisor | output | 5 | Effective divide ratio (1 when the divider is bypassed) |

## Verification
Codes below the PLL floor are tried with both sources. This separates the clamp on the way out from the stored value, and shows whether the clamp leaks into non-PLL operation. The divider request bit is toggled under each source to show that the PLL forces the divider on. Code zero, an all-ones write and a write only to reserved bits probe field isolation. Pulse spacing is measured at ratios 1, 2, 4, 8, 10 and 16 after each change, which exposes counters that are off by one or that are not restarted.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  localparam int CODE_W   = 4;
  localparam int DIV_W    = CODE_W + 1;
  localparam int CODE_LSB = 23;
  localparam int USE_BIT  = 22;
  localparam int PWD_BIT  = 13;
  localparam int OEN_BIT  = 12;
  localparam logic [CODE_W-1:0] MIN_PLL_CODE = 4'd7;
  localparam logic [CODE_W-1:0] RST_CODE     = 4'hF;

  typedef struct packed {
    logic             divActive;
    logic [DIV_W-1:0] ratio;
    logic             reload;
  } div_strobe_t;
endpackage

// File: rtl/clk_cfg_ctrl.sv
module clk_cfg_ctrl
  import clk_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        srcBypass,
  input  logic        cfgWe,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  output logic        pllRunning,
  output div_strobe_t strobe
);
  localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

  logic [CODE_W-1:0] codeReg;
  logic              useDivReg;
  logic              pwrDnReg;
  logic              oenReg;
  logic [DIV_W-1:0]  ratioReg;
  logic [CODE_W-1:0] codeEff;
  logic [DIV_W-1:0]  ratioNow;
  logic              divActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeReg   <= RST_CODE;
      useDivReg <= 1'b0;
      pwrDnReg  <= 1'b1;
      oenReg    <= 1'b1;
    end else if (cfgWe) begin
      codeReg   <= cfgWdata[CODE_MSB:CODE_LSB];
      useDivReg <= cfgWdata[USE_BIT];
      pwrDnReg  <= cfgWdata[PWD_BIT];
      oenReg    <= cfgWdata[OEN_BIT];
    end
  end

  // Clamp applies on the way out only; the stored code stays as written.
  always_comb begin
    codeEff = codeReg;
    if (!srcBypass && codeReg < MIN_PLL_CODE) codeEff = MIN_PLL_CODE;
  end

  assign divActive = useDivReg | ~srcBypass;

  always_comb begin
    if (srcBypass && codeReg == '0) ratioNow = DIV_W'(2);
    else                            ratioNow = {1'b0, codeEff} + 1'b1;
  end

  always_comb begin
    cfgRdata                   = '0;
    cfgRdata[CODE_MSB:CODE_LSB] = codeEff;
    cfgRdata[USE_BIT]          = useDivReg;
    cfgRdata[PWD_BIT]          = pwrDnReg;
    cfgRdata[OEN_BIT]          = oenReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ratioReg <= {1'b0, RST_CODE} + 1'b1;
    else       ratioReg <= divActive ? ratioNow : DIV_W'(1);
  end

  assign pllRunning = ~pwrDnReg & ~oenReg;

  always_comb begin
    strobe.divActive = divActive;
    strobe.ratio     = ratioNow;
    strobe.reload    = (divActive ? ratioNow : DIV_W'(1)) != ratioReg;
  end

  // R4: readback never shows a code under the floor with the PLL source
  assert_rd_clamp_R4: assert property (@(posedge clk) disable iff (!rstN)
    !srcBypass |-> cfgRdata[CODE_MSB:CODE_LSB] >= MIN_PLL_CODE);
endmodule

// File: rtl/clk_cfg_datapath.sv
module clk_cfg_datapath
  import clk_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  div_strobe_t strobe,
  output logic        sysClkEn
);
  logic [DIV_W-1:0] cnt;
  logic             atEnd;

  assign atEnd = (cnt == strobe.ratio - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN)                                cnt <= '0;
    else if (strobe.reload || !strobe.divActive) cnt <= '0;
    else if (atEnd)                           cnt <= '0;
    else                                      cnt <= cnt + 1'b1;
  end

  assign sysClkEn = !strobe.divActive || (atEnd && !strobe.reload);

  // R9: counter stays within the current ratio
  assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.divActive && !strobe.reload) |-> cnt < strobe.ratio);

  // R9: an active-divider pulse lasts a single cycle
  assert_pulse_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.divActive && sysClkEn && !strobe.reload) |=> (!sysClkEn || !strobe.divActive));
endmodule

// File: rtl/clk_cfg_divider.sv
module clk_cfg_divider
  import clk_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        srcBypass,
  input  logic        cfgWe,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  output logic        sysClkEn,
  output logic        pllRunning,
  output logic [4:0]  effDivisor
);
  div_strobe_t strobe;

  clk_cfg_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .srcBypass(srcBypass), .cfgWe(cfgWe),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .pllRunning(pllRunning),
    .strobe(strobe)
  );

  clk_cfg_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sysClkEn(sysClkEn)
  );

  assign effDivisor = strobe.divActive ? strobe.ratio : 5'd1;

  // R3: PLL-derived ratio never below /8
  assert_min_div_R3: assert property (@(posedge clk) disable iff (!rstN)
    !srcBypass |-> effDivisor >= 5'd8);

  // R8: running flag only with both control bits clear in the readback
  assert_pll_run_R8: assert property (@(posedge clk) disable iff (!rstN)
    pllRunning |-> (!cfgRdata[PWD_BIT] && !cfgRdata[OEN_BIT]));
endmodule

// File: tb/test_clk_cfg_divider.sv
module test_clk_cfg_divider;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        srcBypass = 1'b0;
  logic        cfgWe = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        sysClkEn;
  logic        pllRunning;
  logic [4:0]  effDivisor;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clk_cfg_divider i_clk_cfg_divider (
    .clk(clk), .rstN(rstN), .srcBypass(srcBypass), .cfgWe(cfgWe),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .sysClkEn(sysClkEn),
    .pllRunning(pllRunning), .effDivisor(effDivisor)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0; cfgWdata = '0;
  endtask

  task automatic measurePeriod(input string tag, input int exp);
    int n = 0;
    int guard = 0;
    repeat (3) @(negedge clk);
    while (!sysClkEn && guard < 40) begin @(negedge clk); guard++; end
    do begin @(negedge clk); n++; end while (!sysClkEn && n < 40);
    check(tag, n, exp);
  endtask

  task automatic testReset();
    check("R1 reset readback", cfgRdata, 32'h0780_3000);
    check("R8 reset pllRunning", {31'd0, pllRunning}, 32'd0);
    check("R3 reset effDivisor", {27'd0, effDivisor}, 32'd16);
    measurePeriod("R9 reset period 16", 16);
  endtask

  task automatic testPllClamp();
    srcBypass = 1'b0;
    writeCfg(32'h0180_0000);               // code 3, no divider request
    check("R4 clamped readback", cfgRdata, 32'h0380_0000);
    check("R3 forced clamped divisor", {27'd0, effDivisor}, 32'd8);
    measurePeriod("R9 period 8", 8);
  endtask

  task automatic testExposeLowCode();
    @(negedge clk); srcBypass = 1'b1;
    @(negedge clk);
    check("R5 stored code exposed", cfgRdata, 32'h0180_0000);
    check("R6 no request passes through", {27'd0, effDivisor}, 32'd1);
    measurePeriod("R6 enable every cycle", 1);
    writeCfg(32'h01C0_0000);               // code 3, request divider
    check("R5 low code used", {27'd0, effDivisor}, 32'd4);
    measurePeriod("R9 period 4", 4);
  endtask

  task automatic testCodeZero();
    writeCfg(32'h0040_0000);
    check("R7 code zero readback", cfgRdata, 32'h0040_0000);
    check("R7 code zero divisor", {27'd0, effDivisor}, 32'd2);
    measurePeriod("R7 period 2", 2);
  endtask

  task automatic testReserved();
    writeCfg(32'hFFFF_FFFF);
    check("R10 all-ones readback", cfgRdata, 32'h07C0_3000);
    check("R2 all-ones divisor", {27'd0, effDivisor}, 32'd16);
    writeCfg(32'h04FF_C000);               // code 9, request, bits 21:14 set
    check("R10 reserved bits ignored", cfgRdata, 32'h04C0_0000);
    check("R2 code 9 divisor", {27'd0, effDivisor}, 32'd10);
    measurePeriod("R9 period 10", 10);
  endtask

  task automatic testPllRun();
    writeCfg(32'h0480_0000);
    check("R8 both clear running", {31'd0, pllRunning}, 32'd1);
    writeCfg(32'h0480_2000);
    check("R8 power-down stops", {31'd0, pllRunning}, 32'd0);
    writeCfg(32'h0480_1000);
    check("R8 output disable stops", {31'd0, pllRunning}, 32'd0);
  endtask

  task automatic testForcedDivider();
    @(negedge clk); srcBypass = 1'b0;
    @(negedge clk);
    check("R3 forced divider code 9", {27'd0, effDivisor}, 32'd10);
    check("R2 readback code 9 PLL", cfgRdata, 32'h0480_1000);
    measurePeriod("R9 PLL period 10", 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPllClamp();
    testExposeLowCode();
    testCodeZero();
    testReserved();
    testPllRun();
    testForcedDivider();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule